// File: doc/BRIEF.md
# Dual-Register Toggle Controller

This block decides, for each of eight output channels, when the channel's active code register is reloaded and whether the new value comes from input register A or input register B. It keeps an 8-bit select mask and a software toggle bit. Both are loaded by decoded commands, each of which arrives as a one-cycle strobe with a 4-bit opcode and 16 data bits. It also watches an asynchronous toggle pin. The pin is passed through a synchroniser and then edge-detected.

The effective toggle level is the AND of the software bit and the synchronised pin. When this level falls, every selected channel reloads from A. When it rises, every selected channel reloads from B. A steady level never causes a reload. A separate general update request reloads all eight channels at once. For that request, a channel loads from B only if its select bit is set and the effective level is high.

The select mask is also driven out to the register bank, where it steers code writes into register B instead of A. Register storage and serial reception live elsewhere.

Top module: `tgl_ctrl_top`

## Requirements
- R1: A command with opcode 4'b1100 loads the select mask from cmd_data[7:0], with bit x belonging to channel x. The mask appears on wr_to_b after the command's clock edge. Data bits 15:8 and every other opcode leave the mask unchanged.
- R2: A command with opcode 4'b1101 sets the software toggle bit to cmd_data[0]. The other data bits are ignored. The bit is 1 after reset.
- R3: After reset, wr_to_b, ld_strobe and ld_from_b are all zero.
- R4: A 1-to-0 change of the effective toggle level raises ld_strobe for the selected channels only, with ld_from_b all zero.
- R5: A 0-to-1 change of the effective toggle level raises ld_strobe for the selected channels only, and ld_from_b equals the mask.
- R6: A change of tog_pin passes through a two-flop synchroniser. The resulting strobe appears after the third rising clock edge following the change, and not before.
- R7: A steady effective level produces no strobe. A toggle event never strobes a channel whose select bit is 0.
- R8: A general update request (upd_all) raises all eight ld_strobe bits after the next clock edge. ld_from_b then equals the mask ANDed with the effective level.
- R9: The effective level is the AND of the software bit and the synchronised pin. Writing the software bit with its current value causes no strobe. Pin edges while the bit is 0 cause no strobe. Changing the bit while the pin is low causes no strobe.
- R10: Strobes are one-cycle pulses, and ld_from_b is never set for a channel whose ld_strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_data | input | 16 | Command data |
| tog_pin | input | 1 | Asynchronous toggle pin |
| upd_all | input | 1 | General update request for all channels |
| wr_to_b | output | 8 | Select mask; steers code writes to register B |
| ld_strobe | output | 8 | Per-channel reload strobe |
| ld_from_b | output | 8 | Per-channel source select (1 = B, 0 = A), valid with ld_strobe |

## Verification
The results arrive at different latencies:
- A mask write shows on wr_to_b right after the command's own clock edge.
- A general update strobe also appears right after the request edge.
- A software-bit write that changes the effective level strobes one edge after the command edge, because the level edge is registered once.
- A pin change strobes after the third edge, because two synchroniser flops come before the output register.

The bench drives all inputs at falling clock edges and counts falling edges to the exact sampling point for each case. At every intermediate falling edge it checks that the strobes are still zero. On the falling edge after a pulse it checks that the strobes have returned to zero.

// File: rtl/tgl_pkg.sv
package tgl_pkg;
  localparam logic [3:0] OP_SEL_MASK = 4'b1100;
  localparam logic [3:0] OP_SW_TOG   = 4'b1101;

  // channel reloads on a general update, or on a toggle edge when selected
  function automatic logic strobe_bit(input logic sel, input logic tog_edge,
                                      input logic upd);
    return upd | (sel & tog_edge);
  endfunction

  // source is B only for a selected channel while the effective level is high
  function automatic logic src_is_b(input logic sel, input logic level);
    return sel & level;
  endfunction
endpackage

// File: rtl/tgl_sync.sv
module tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] st_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[0] <= 1'b0;
          else        st_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[i] <= 1'b0;
          else        st_q[i] <= st_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = st_q[STAGES-1];

  // R6
  sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sync_out == $past(st_q[STAGES-2 >= 0 ? STAGES-2 : 0]));
endmodule

// File: rtl/tgl_regs.sv
module tgl_regs
  import tgl_pkg::*;
#(
  parameter int NCH = 8,
  parameter int OPW = 4,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [OPW-1:0] cmd_op,
  input  logic [DW-1:0]  cmd_data,
  output logic [NCH-1:0] mask_q,
  output logic           swbit_q
);
  logic wr_mask, wr_sw;
  assign wr_mask = cmd_valid && (cmd_op == OP_SEL_MASK);
  assign wr_sw   = cmd_valid && (cmd_op == OP_SW_TOG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= cmd_data[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     swbit_q <= 1'b1;
    else if (wr_sw) swbit_q <= cmd_data[0];
  end

  // R1
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask_q == $past(cmd_data[NCH-1:0]));
  // R1
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
  // R2
  swbit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sw |=> swbit_q == $past(cmd_data[0]));
endmodule

// File: rtl/tgl_edge.sv
module tgl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic swbit,
  input  logic pin_s,
  output logic level,
  output logic rise,
  output logic fall
);
  logic prev_q;

  assign level = swbit & pin_s;
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  // R9
  rise_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (swbit && pin_s));
  // R7
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
endmodule

// File: rtl/tgl_strobe.sv
module tgl_strobe
  import tgl_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] mask,
  input  logic           level,
  input  logic           rise,
  input  logic           fall,
  input  logic           upd,
  output logic [NCH-1:0] ld_strobe,
  output logic [NCH-1:0] ld_from_b
);
  logic any_edge;
  assign any_edge = rise | fall;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic fire;
      assign fire = strobe_bit(mask[g], any_edge, upd);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ld_strobe[g] <= 1'b0;
          ld_from_b[g] <= 1'b0;
        end else begin
          ld_strobe[g] <= fire;
          ld_from_b[g] <= fire & src_is_b(mask[g], level);
        end
      end
    end
  endgenerate

  // R4
  fall_src_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !upd) |=> (ld_strobe == $past(mask)) && (ld_from_b == '0));
  // R5
  rise_src_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !upd) |=> (ld_strobe == $past(mask)) && (ld_from_b == $past(mask)));
  // R8
  upd_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (&ld_strobe));
  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !fall && !upd) |=> (ld_strobe == '0));
  // R10
  src_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_from_b & ~ld_strobe) == '0);
endmodule

// File: rtl/tgl_ctrl_top.sv
module tgl_ctrl_top #(
  parameter int NCH         = 8,
  parameter int OPW         = 4,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [OPW-1:0] cmd_op,
  input  logic [DW-1:0]  cmd_data,
  input  logic           tog_pin,
  input  logic           upd_all,
  output logic [NCH-1:0] wr_to_b,
  output logic [NCH-1:0] ld_strobe,
  output logic [NCH-1:0] ld_from_b
);
  logic [NCH-1:0] mask_q;
  logic           swbit_q;
  logic           pin_s;
  logic           eff_level, eff_rise, eff_fall;

  tgl_regs #(.NCH(NCH), .OPW(OPW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .mask_q(mask_q), .swbit_q(swbit_q)
  );

  tgl_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(tog_pin), .sync_out(pin_s)
  );

  tgl_edge edge_i (
    .clk(clk), .rst_n(rst_n), .swbit(swbit_q), .pin_s(pin_s),
    .level(eff_level), .rise(eff_rise), .fall(eff_fall)
  );

  tgl_strobe #(.NCH(NCH)) strobe_i (
    .clk(clk), .rst_n(rst_n), .mask(mask_q), .level(eff_level),
    .rise(eff_rise), .fall(eff_fall), .upd(upd_all),
    .ld_strobe(ld_strobe), .ld_from_b(ld_from_b)
  );

  assign wr_to_b = mask_q;

  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_strobe != '0 && !upd_all && !eff_rise && !eff_fall) |=> ld_strobe == '0);
endmodule

// File: tb/tgl_ctrl_top_tb_top.sv
module tgl_ctrl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [15:0] cmd_data = '0;
  logic        tog_pin = 1'b0;
  logic        upd_all = 1'b0;
  logic [7:0]  wr_to_b, ld_strobe, ld_from_b;

  int total = 0;
  int bad = 0;

  logic [7:0] m_mask;
  logic       m_sw;
  logic       m_pin;

  always #5 clk = ~clk;

  tgl_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .tog_pin(tog_pin), .upd_all(upd_all),
    .wr_to_b(wr_to_b), .ld_strobe(ld_strobe), .ld_from_b(ld_from_b)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic now_out(input logic [7:0] es, input logic [7:0] eb, input string tag);
    chk(ld_strobe, es, {tag, " strobe"});
    chk(ld_from_b, eb, {tag, " src"});
  endtask

  // pulse due at the next falling edge, gone at the one after
  task automatic expect_pulse(input logic [7:0] es, input logic [7:0] eb, input string tag);
    @(negedge clk);
    now_out(es, eb, tag);
    @(negedge clk);
    now_out(8'h00, 8'h00, {tag, " R10 pulse end"});
  endtask

  task automatic cmd(input logic [3:0] op, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'h0; cmd_data = '0;
  endtask

  // software bit write; pulse expected one edge after the command edge
  task automatic sw_write(input logic [15:0] d, input string tag);
    logic old_l, new_l;
    old_l = m_sw & m_pin;
    m_sw  = d[0];
    new_l = m_sw & m_pin;
    cmd(4'b1101, d);
    if (old_l == new_l)      expect_pulse(8'h00, 8'h00, tag);
    else if (new_l)          expect_pulse(m_mask, m_mask, tag);
    else                     expect_pulse(m_mask, 8'h00, tag);
  endtask

  // pin change; strobe after the third rising edge
  task automatic pin_set(input logic v, input string tag);
    logic old_l, new_l;
    old_l = m_sw & m_pin;
    m_pin = v;
    new_l = m_sw & m_pin;
    @(negedge clk);
    tog_pin = v;
    @(negedge clk);
    now_out(8'h00, 8'h00, {tag, " R6 early1"});
    @(negedge clk);
    now_out(8'h00, 8'h00, {tag, " R6 early2"});
    if (old_l == new_l)      expect_pulse(8'h00, 8'h00, tag);
    else if (new_l)          expect_pulse(m_mask, m_mask, tag);
    else                     expect_pulse(m_mask, 8'h00, tag);
  endtask

  task automatic set_mask(input logic [7:0] m);
    m_mask = m;
    cmd(4'b1100, {8'hA5, m});
    chk(wr_to_b, m, "R1 mask load");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_mask = 8'h00; m_sw = 1'b1; m_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3
    chk(wr_to_b, 8'h00, "R3 reset mask");
    now_out(8'h00, 8'h00, "R3 reset");

    // R1 sweep of all mask values, upper data bits set to ignored pattern
    for (int m = 0; m < 256; m++) begin
      set_mask(m[7:0]);
      now_out(8'h00, 8'h00, "R7 no strobe on mask write");
    end
    // R1 other opcodes leave mask alone
    set_mask(8'h3C);
    for (int op = 0; op < 16; op++) begin
      if (op != 12) begin
        if (op == 13) sw_write(16'h0001, "R9 same sw value");
        else begin
          cmd(op[3:0], 16'hFFC3);
          chk(wr_to_b, 8'h3C, "R1 mask held");
        end
      end
    end

    // R2 reset value of sw bit is 1: pin rise produces B reload
    set_mask(8'h5A);
    pin_set(1'b1, "R5 R2 pin rise reload B");
    pin_set(1'b1, "R7 pin steady");
    sw_write(16'h0000, "R4 sw fall reload A");
    sw_write(16'h0000, "R9 sw same value");
    sw_write(16'hFFFF, "R5 sw rise reload B");
    sw_write(16'hFFFE, "R2 data bit0 only");
    pin_set(1'b0, "R9 pin fall sw low");
    pin_set(1'b1, "R9 pin rise sw low");
    sw_write(16'h0001, "R5 sw rise after pin");
    pin_set(1'b0, "R4 pin fall reload A");
    sw_write(16'h0000, "R9 sw change pin low");
    sw_write(16'h0001, "R9 sw change pin low");

    // R4 R5 R7 across several masks via pin edges
    foreach (m_pats[i]) begin
      set_mask(m_pats[i]);
      pin_set(1'b1, "R5 pin rise sweep");
      pin_set(1'b0, "R4 pin fall sweep");
    end

    // R8 general update sweep over masks and levels
    for (int m = 0; m < 256; m += 17) begin
      set_mask(m[7:0]);
      for (int lv = 0; lv < 2; lv++) begin
        pin_set(lv[0], "R8 level setup");
        @(negedge clk);
        upd_all = 1'b1;
        @(negedge clk);
        upd_all = 1'b0;
        now_out(8'hFF, m[7:0] & {8{m_sw & m_pin}}, "R8 update all");
        @(negedge clk);
        now_out(8'h00, 8'h00, "R10 update pulse end");
      end
    end
    pin_set(1'b0, "R4 final fall");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [7:0] m_pats [5] = '{8'h01, 8'h80, 8'hFF, 8'h00, 8'hC3};
endmodule